// File: doc/BRIEF.md
# NAND Reed-Solomon ECC Register Front-End

This block is the software-visible face of a NAND Reed-Solomon ECC engine. It sits on a simple 32-bit register bus with per-byte write enables. Software uses it to start an encode or a decode session, to load or read back the nine parity bytes, to poll or take an interrupt on completion, and to fetch the error records that the engine produced. The arithmetic engine lives outside. It connects through a codec-side port that receives mode and control levels and returns completion pulses, error flags, an error count and per-error records.

In an encode session the engine's parity result is captured into the parity window when it signals completion. A parity value that matches the code of an all-erased page is stored as nine bytes of 0xFF instead. In a decode session software writes the stored parity byte by byte and then raises the parity-ready bit, which lets the engine start correcting. On completion the status word gathers the error flags and a 3-bit error count, and the record array latches the position and mask of each reported error.

Top module: `ecc_csr_front`

## Requirements
- R1: After reset every register reads 0, irq is 0 and all engine control outputs are 0.
- R2: The control word (word offset 0x00) holds enable in bit 0, RS mode in bit 2, encode mode in bit 3 (1 computes parity, 0 decodes) and parity-ready in bit 4. It is written through byte lane 0, reads back as written, and drives eng_en, eng_rs and eng_encode.
- R3: Writing 1 to control bit 1 raises eng_clear for exactly one cycle, after which the bit reads 0. The same write empties the parity window and every error record.
- R4: Parity byte k (0..8) lives at address 0x08+k, in byte lane k mod 4 of the words at 0x08, 0x0C and 0x10. Each byte is written only when its lane enable is set. Lanes 1..3 of 0x10 read 0 and ignore writes. The window is also driven onto eng_par_out with byte k at bits 8k+7..8k.
- R5: eng_par_rdy is high only while enable is 1, encode mode is 0 and parity-ready is 1.
- R6: While enabled in encode mode, a pulse on eng_enc_done loads eng_par_in into the parity window and sets status bit 2.
- R7: If the captured parity equals bytes 0..8 = cd 9d 90 58 f4 8b ff b7 6f, the window holds nine 0xFF bytes instead. A value that differs in any one byte is stored unchanged.
- R8: While enabled in decode mode, a pulse on eng_dec_done sets status bit 3. It sets bit 0 if eng_err is high and bit 1 if eng_uncor is high, and loads eng_err_cnt into status bits 31:29.
- R9: On that decode completion, record i (address 0x1C+4i, four records) is loaded with the 9-bit position in bits 24:16 and the 9-bit mask in bits 8:0 when i is below the count, and 0 otherwise. A count above 4 fills all four records. Addresses past the last record read 0.
- R10: A write to the status word (0x14) whose enabled lanes are all zero clears every flag and the count. A write carrying any 1 bit changes nothing. A completion event in the same cycle as a clear still sets its flags.
- R11: While enable is 0, engine completion pulses change neither the status word, the parity window nor the records.
- R12: The interrupt-control word (0x18, bits 4:0) reads back as written. irq is the OR of status bits 4:0 masked by it, and status bit 4 is set by eng_pad_done while enabled.
- R13: A write to the data port (0x04) merges the enabled byte lanes into a register that reads back and drives eng_dout. eng_dvld pulses for one cycle after the write only when enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (same cycle) |
| irq | output | 1 | Masked completion interrupt |
| eng_en | output | 1 | Session enabled |
| eng_rs | output | 1 | RS mode select |
| eng_encode | output | 1 | 1 encode, 0 decode |
| eng_clear | output | 1 | One-cycle engine clear |
| eng_par_rdy | output | 1 | Parity loaded, start correction |
| eng_dout | output | 32 | Data port value |
| eng_dvld | output | 1 | Data port write strobe |
| eng_par_out | output | 72 | Parity window contents |
| eng_par_in | input | 72 | Parity from engine at encode finish |
| eng_enc_done | input | 1 | Encode finished pulse |
| eng_dec_done | input | 1 | Decode finished pulse |
| eng_pad_done | input | 1 | Padding finished pulse |
| eng_err | input | 1 | Errors found (with decode finish) |
| eng_uncor | input | 1 | Errors uncorrectable (with decode finish) |
| eng_err_cnt | input | 3 | Error count (with decode finish) |
| eng_err_pos | input | SLOTS*9 | Per-record symbol positions |
| eng_err_mask | input | SLOTS*9 | Per-record error masks |

## Verification
The encode path gets three parity inputs. An ordinary value checks the byte placement across the three window words. The exact erased-page pattern checks the all-ones substitution. A pattern that differs from it in the last byte only shows that the comparison covers all nine bytes. The decode path gets a count of 2, which separates filled records from zeroed ones, and a count of 6, which shows the four-record limit and the zero read past the array. Completion pulses repeated with enable low show that stored results are held. Single-lane, multi-lane and out-of-range-lane writes to the parity window and the data port exercise the byte-lane handling. A nonzero write and a zero write to the status word exercise the clear rule.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  localparam int PAR_BYTES = 9;
  localparam int PAR_W     = PAR_BYTES * 8;
  localparam int PAR_WORDS = (PAR_BYTES + 3) / 4;
  localparam int POS_W     = 9;
  localparam int MASK_W    = 9;
  localparam int CNT_W     = 3;
  localparam int FLAG_W    = 5;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_RS   = 2;
  localparam int CB_ENC  = 3;
  localparam int CB_PRDY = 4;

  // status bit positions
  localparam int SB_ERR   = 0;
  localparam int SB_UNCOR = 1;
  localparam int SB_ENCF  = 2;
  localparam int SB_DECF  = 3;
  localparam int SB_PADF  = 4;
  localparam int CNT_LSB  = 29;

  // word offsets (byte address / 4)
  localparam int WA_CTRL = 0;
  localparam int WA_DATA = 1;
  localparam int WA_PAR  = 2;
  localparam int WA_STAT = 5;
  localparam int WA_IMSK = 6;
  localparam int WA_ERR  = 7;

  // parity of a fully erased page, byte 0 in the low bits
  localparam logic [PAR_W-1:0] ERASED_PAR = 72'h6f_b7_ff_8b_f4_58_90_9d_cd;

  typedef struct packed {
    logic prdy;
    logic enc;
    logic rs;
    logic clr;
    logic en;
  } ctrl_t;

  function automatic logic [PAR_W-1:0] erased_remap(input logic [PAR_W-1:0] p);
    return (p == ERASED_PAR) ? {PAR_W{1'b1}} : p;
  endfunction

  function automatic logic [31:0] err_word(input logic [POS_W-1:0] pos,
                                           input logic [MASK_W-1:0] msk);
    return {7'd0, pos, 7'd0, msk};
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/ecc_par_window.sv
module ecc_par_window
  import ecc_csr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   cap,
  input  logic [PAR_W-1:0]       cap_val,
  input  logic                   wr,
  input  logic [1:0]             wsel,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  output logic [PAR_W-1:0]       par_q,
  output logic [PAR_WORDS*32-1:0] rd_words
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0;
    end else if (clr) begin
      par_q <= '0;
    end else if (cap) begin
      par_q <= erased_remap(cap_val);
    end else if (wr) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b] && ((int'(wsel) * 4 + b) < PAR_BYTES))
          par_q[(int'(wsel) * 4 + b) * 8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < PAR_WORDS * 4; k++) begin : g_byte
      if (k < PAR_BYTES) begin : g_live
        assign rd_words[k*8 +: 8] = par_q[k*8 +: 8];
      end else begin : g_pad
        assign rd_words[k*8 +: 8] = 8'h00;
      end
    end
  endgenerate
endmodule

// File: rtl/ecc_stat_unit.sv
module ecc_stat_unit
  import ecc_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enc_ev,
  input  logic              dec_ev,
  input  logic              pad_ev,
  input  logic              err_in,
  input  logic              uncor_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              imsk_we,
  input  logic [FLAG_W-1:0] imsk_in,
  output logic [31:0]       stat_q,
  output logic [FLAG_W-1:0] imsk_q,
  output logic              irq,
  output logic              any_set
);
  logic [FLAG_W-1:0] flags, set_vec;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    set_vec           = '0;
    set_vec[SB_ERR]   = dec_ev & err_in;
    set_vec[SB_UNCOR] = dec_ev & uncor_in;
    set_vec[SB_ENCF]  = enc_ev;
    set_vec[SB_DECF]  = dec_ev;
    set_vec[SB_PADF]  = pad_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      cnt    <= '0;
      imsk_q <= '0;
    end else begin
      flags <= (clr ? '0 : flags) | set_vec;
      if (dec_ev)   cnt <= cnt_in;
      else if (clr) cnt <= '0;
      if (imsk_we) imsk_q <= imsk_in;
    end
  end

  assign stat_q  = {cnt, {(CNT_LSB-FLAG_W){1'b0}}, flags};
  assign irq     = |(flags & imsk_q);
  assign any_set = |set_vec;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_csr_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    cap,
  input  logic [CNT_W-1:0]        cnt_in,
  input  logic [SLOTS*POS_W-1:0]  pos_in,
  input  logic [SLOTS*MASK_W-1:0] mask_in,
  output logic [SLOTS*32-1:0]     recs_q
);
  logic [31:0] rec [SLOTS];

  genvar i;
  generate
    for (i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rec[i] <= '0;
        else if (clr)  rec[i] <= '0;
        else if (cap)  rec[i] <= (int'(cnt_in) > i)
                                 ? err_word(pos_in[i*POS_W +: POS_W], mask_in[i*MASK_W +: MASK_W])
                                 : 32'd0;
      end
      assign recs_q[i*32 +: 32] = rec[i];
    end
  endgenerate
endmodule

// File: rtl/ecc_csr_front.sv
module ecc_csr_front
  import ecc_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [3:0]              bus_be,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    irq,
  output logic                    eng_en,
  output logic                    eng_rs,
  output logic                    eng_encode,
  output logic                    eng_clear,
  output logic                    eng_par_rdy,
  output logic [31:0]             eng_dout,
  output logic                    eng_dvld,
  output logic [PAR_W-1:0]        eng_par_out,
  input  logic [PAR_W-1:0]        eng_par_in,
  input  logic                    eng_enc_done,
  input  logic                    eng_dec_done,
  input  logic                    eng_pad_done,
  input  logic                    eng_err,
  input  logic                    eng_uncor,
  input  logic [CNT_W-1:0]        eng_err_cnt,
  input  logic [SLOTS*POS_W-1:0]  eng_err_pos,
  input  logic [SLOTS*MASK_W-1:0] eng_err_mask
);
  localparam int WA_W = ADDR_W - 2;
  localparam int ES_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // address decode
  logic [WA_W-1:0] wa;
  logic            unused_lsb;
  logic            bus_we;
  logic            hit_ctrl, hit_data, hit_par, hit_stat, hit_imsk, hit_err;
  logic [1:0]      par_sel;
  logic [ES_W-1:0] err_sel;

  assign wa         = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign bus_we     = bus_sel & bus_wr;
  assign hit_ctrl   = (wa == WA_W'(WA_CTRL));
  assign hit_data   = (wa == WA_W'(WA_DATA));
  assign hit_par    = (wa >= WA_W'(WA_PAR)) && (wa < WA_W'(WA_PAR + PAR_WORDS));
  assign hit_stat   = (wa == WA_W'(WA_STAT));
  assign hit_imsk   = (wa == WA_W'(WA_IMSK));
  assign hit_err    = (wa >= WA_W'(WA_ERR)) && (wa < WA_W'(WA_ERR + SLOTS));
  assign par_sel    = 2'(wa - WA_W'(WA_PAR));
  assign err_sel    = ES_W'(wa - WA_W'(WA_ERR));

  // named internal events
  logic ctrl_we, sess_clr, enc_cap, dec_cap, pad_ev, stat_clear, imsk_we, erased_hit;
  logic any_set;

  ctrl_t       ctrl_q;
  logic [31:0] data_q;
  logic        dvld_q;

  assign ctrl_we    = bus_we & hit_ctrl & bus_be[0];
  assign sess_clr   = ctrl_we & bus_wdata[CB_CLR];
  assign enc_cap    = ctrl_q.en &  ctrl_q.enc & eng_enc_done;
  assign dec_cap    = ctrl_q.en & ~ctrl_q.enc & eng_dec_done;
  assign pad_ev     = ctrl_q.en & eng_pad_done;
  assign stat_clear = bus_we & hit_stat & ((bus_wdata & lane_mask(bus_be)) == 32'd0);
  assign imsk_we    = bus_we & hit_imsk & bus_be[0];
  assign erased_hit = (eng_par_in == ERASED_PAR);

  // control word with self-clearing clear bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q.clr <= 1'b0;
      if (ctrl_we) ctrl_q <= ctrl_t'(bus_wdata[FLAG_W-1:0]);
    end
  end

  // data port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dvld_q <= 1'b0;
    end else begin
      dvld_q <= bus_we & hit_data & ctrl_q.en;
      if (bus_we && hit_data)
        data_q <= (data_q & ~lane_mask(bus_be)) | (bus_wdata & lane_mask(bus_be));
    end
  end

  // parity window
  logic [PAR_W-1:0]        par_q;
  logic [PAR_WORDS*32-1:0] par_words;

  ecc_par_window u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sess_clr),
    .cap      (enc_cap),
    .cap_val  (eng_par_in),
    .wr       (bus_we & hit_par),
    .wsel     (par_sel),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .par_q    (par_q),
    .rd_words (par_words)
  );

  // status and interrupt mask
  logic [31:0]       stat_q;
  logic [FLAG_W-1:0] imsk_q;

  ecc_stat_unit u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stat_clear),
    .enc_ev   (enc_cap),
    .dec_ev   (dec_cap),
    .pad_ev   (pad_ev),
    .err_in   (eng_err),
    .uncor_in (eng_uncor),
    .cnt_in   (eng_err_cnt),
    .imsk_we  (imsk_we),
    .imsk_in  (bus_wdata[FLAG_W-1:0]),
    .stat_q   (stat_q),
    .imsk_q   (imsk_q),
    .irq      (irq),
    .any_set  (any_set)
  );

  // error records
  logic [SLOTS*32-1:0] recs_q;

  ecc_err_log #(.SLOTS(SLOTS)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sess_clr),
    .cap     (dec_cap),
    .cnt_in  (eng_err_cnt),
    .pos_in  (eng_err_pos),
    .mask_in (eng_err_mask),
    .recs_q  (recs_q)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = {{(32-FLAG_W){1'b0}}, ctrl_q};
    else if (hit_data) bus_rdata = data_q;
    else if (hit_par)  bus_rdata = par_words[int'(par_sel)*32 +: 32];
    else if (hit_stat) bus_rdata = stat_q;
    else if (hit_imsk) bus_rdata = {{(32-FLAG_W){1'b0}}, imsk_q};
    else if (hit_err)  bus_rdata = recs_q[int'(err_sel)*32 +: 32];
  end

  // engine-side outputs
  assign eng_en      = ctrl_q.en;
  assign eng_rs      = ctrl_q.rs;
  assign eng_encode  = ctrl_q.enc;
  assign eng_clear   = ctrl_q.clr;
  assign eng_par_rdy = ctrl_q.en & ~ctrl_q.enc & ctrl_q.prdy;
  assign eng_dout    = data_q;
  assign eng_dvld    = dvld_q;
  assign eng_par_out = par_q;
endmodule

// File: rtl/ecc_csr_chk.sv
module ecc_csr_chk
  import ecc_csr_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic                sess_clr,
  input logic                eng_clear,
  input logic                enc_cap,
  input logic                dec_cap,
  input logic                erased_hit,
  input logic                stat_clear,
  input logic                any_set,
  input logic [31:0]         stat_q,
  input logic [PAR_W-1:0]    par_q,
  input logic [SLOTS*32-1:0] recs_q,
  input logic [CNT_W-1:0]    eng_err_cnt,
  input logic                eng_en,
  input logic                eng_encode,
  input logic                eng_par_rdy
);
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clear && !sess_clr |=> !eng_clear); // R3

  AST_CLEAR_WIPES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sess_clr |=> (par_q == '0) && (recs_q == '0)); // R3

  AST_PRDY_DECODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_par_rdy |-> eng_en && !eng_encode); // R5

  AST_ERASED_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    enc_cap && erased_hit && !sess_clr |=> par_q == {PAR_W{1'b1}}); // R7

  AST_COUNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_cap |=> stat_q[31:29] == $past(eng_err_cnt)); // R8

  AST_STATUS_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clear && !any_set |=> stat_q == 32'd0); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en && !bus_we |=> $stable(par_q) && $stable(recs_q) && $stable(stat_q)); // R11
endmodule

bind ecc_csr_front ecc_csr_chk #(.SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .sess_clr    (sess_clr),
  .eng_clear   (eng_clear),
  .enc_cap     (enc_cap),
  .dec_cap     (dec_cap),
  .erased_hit  (erased_hit),
  .stat_clear  (stat_clear),
  .any_set     (any_set),
  .stat_q      (stat_q),
  .par_q       (par_q),
  .recs_q      (recs_q),
  .eng_err_cnt (eng_err_cnt),
  .eng_en      (eng_en),
  .eng_encode  (eng_encode),
  .eng_par_rdy (eng_par_rdy)
);

// File: tb/sim_ecc_csr_front.sv
`timescale 1ns/1ps
module sim_ecc_csr_front;
  localparam int SLOTS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [3:0]        bus_be = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq, eng_en, eng_rs, eng_encode, eng_clear, eng_par_rdy, eng_dvld;
  logic [31:0]       eng_dout;
  logic [71:0]       eng_par_out;
  logic [71:0]       eng_par_in = '0;
  logic              eng_enc_done = 1'b0, eng_dec_done = 1'b0, eng_pad_done = 1'b0;
  logic              eng_err = 1'b0, eng_uncor = 1'b0;
  logic [2:0]        eng_err_cnt = '0;
  logic [SLOTS*9-1:0] eng_err_pos = '0, eng_err_mask = '0;

  always #2 clk = ~clk;

  ecc_csr_front #(.ADDR_W(8), .SLOTS(SLOTS)) u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } rd_item_t;
  rd_item_t rd_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // driver tasks
  task automatic wr_reg(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string req);
    rd_item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'h0;
    it.exp = exp; it.req = req;
    rd_q.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input bit enc, input bit dec, input bit pad);
    @(negedge clk);
    eng_enc_done = enc; eng_dec_done = dec; eng_pad_done = pad;
    @(negedge clk);
    eng_enc_done = 1'b0; eng_dec_done = 1'b0; eng_pad_done = 1'b0;
  endtask

  // monitor: pops expected read data
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_sel && !bus_wr) begin
        if (rd_q.size() == 0) check("queue", 32'hdead, 32'h0);
        else begin
          rd_item_t it;
          it = rd_q.pop_front();
          check(it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  // bench-side reference values
  function automatic logic [71:0] erased_val();
    logic [7:0] b [9];
    logic [71:0] v;
    b = '{8'hcd, 8'h9d, 8'h90, 8'h58, 8'hf4, 8'h8b, 8'hff, 8'hb7, 8'h6f};
    for (int k = 0; k < 9; k++) v[k*8 +: 8] = b[k];
    return v;
  endfunction

  function automatic logic [31:0] rec_val(input logic [8:0] pos, input logic [8:0] msk);
    logic [31:0] r;
    r = 32'd0;
    r[24:16] = pos;
    r[8:0]   = msk;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [71:0] pa, er, near;
    logic [8:0]  p [4];
    logic [8:0]  m [4];
    pa = 72'h11_2233_4455_6677_8899;
    er = erased_val();
    near = er;
    near[71:64] = near[71:64] ^ 8'h40;
    p = '{9'h005, 9'h1ff, 9'h033, 9'h044};
    m = '{9'h101, 9'h0f0, 9'h1aa, 9'h055};
    for (int s = 0; s < 4; s++) begin
      eng_err_pos[s*9 +: 9]  = p[s];
      eng_err_mask[s*9 +: 9] = m[s];
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp(8'h00, 32'h0, "R1 ctrl");
    rd_exp(8'h14, 32'h0, "R1 status");
    rd_exp(8'h08, 32'h0, "R1 parity");
    rd_exp(8'h1C, 32'h0, "R1 record");
    #1;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 eng_en", {31'd0, eng_en}, 32'd0);

    // R2 / R3 encode session start with clear
    wr_reg(8'h00, 4'h1, 32'h0000_000F);
    #1;
    check("R3 clear high", {31'd0, eng_clear}, 32'd1);
    @(negedge clk); #1;
    check("R3 clear one cycle", {31'd0, eng_clear}, 32'd0);
    check("R2 outputs", {29'd0, eng_en, eng_rs, eng_encode}, 32'h7);
    rd_exp(8'h00, 32'h0000_000D, "R2 ctrl readback");

    // R6 encode capture
    eng_par_in = pa;
    pulse(1, 0, 0);
    rd_exp(8'h08, pa[31:0], "R6 parity w0");
    rd_exp(8'h0C, pa[63:32], "R6 parity w1");
    rd_exp(8'h10, {24'd0, pa[71:64]}, "R6 parity w2");
    rd_exp(8'h14, 32'h4, "R6 status");
    #1;
    check("R4 par_out", eng_par_out[31:0], pa[31:0]);

    // R7 erased remap and near miss
    eng_par_in = er;
    pulse(1, 0, 0);
    rd_exp(8'h08, 32'hFFFF_FFFF, "R7 erased w0");
    rd_exp(8'h0C, 32'hFFFF_FFFF, "R7 erased w1");
    rd_exp(8'h10, 32'h0000_00FF, "R7 erased w2");
    eng_par_in = near;
    pulse(1, 0, 0);
    rd_exp(8'h08, near[31:0], "R7 near w0");
    rd_exp(8'h10, {24'd0, near[71:64]}, "R7 near w2");

    // R10 status clear rule
    wr_reg(8'h14, 4'hF, 32'h0000_0004);
    rd_exp(8'h14, 32'h4, "R10 nonzero write ignored");
    wr_reg(8'h14, 4'hF, 32'h0);
    rd_exp(8'h14, 32'h0, "R10 zero write clears");

    // decode session: clear wipes parity
    wr_reg(8'h00, 4'h1, 32'h0000_0007);
    rd_exp(8'h08, 32'h0, "R3 parity wiped");
    wr_reg(8'h08, 4'h1, 32'h0000_00AA);
    rd_exp(8'h08, 32'h0000_00AA, "R4 lane0");
    wr_reg(8'h08, 4'h4, 32'h55CC_3311);
    rd_exp(8'h08, 32'h00CC_00AA, "R4 lane2 only");
    wr_reg(8'h10, 4'hF, 32'hDEAD_BEEF);
    rd_exp(8'h10, 32'h0000_00EF, "R4 byte8 only");
    #1;
    check("R5 prdy low", {31'd0, eng_par_rdy}, 32'd0);
    wr_reg(8'h00, 4'h1, 32'h0000_0015);
    #1;
    check("R5 prdy high", {31'd0, eng_par_rdy}, 32'd1);
    check("R4 par_out decode", {8'd0, eng_par_out[23:0]}, 32'h00CC_00AA);

    // R8 / R9 decode with two errors
    eng_err = 1'b1; eng_uncor = 1'b0; eng_err_cnt = 3'd2;
    pulse(0, 1, 0);
    rd_exp(8'h14, 32'h4000_0009, "R8 status");
    rd_exp(8'h1C, rec_val(p[0], m[0]), "R9 rec0");
    rd_exp(8'h20, rec_val(p[1], m[1]), "R9 rec1");
    rd_exp(8'h24, 32'h0, "R9 rec2 unused");
    rd_exp(8'h28, 32'h0, "R9 rec3 unused");

    // R11 disabled: events ignored
    wr_reg(8'h00, 4'h1, 32'h0000_0014);
    #1;
    check("R5 prdy off when disabled", {31'd0, eng_par_rdy}, 32'd0);
    eng_err = 1'b0; eng_err_cnt = 3'd1; eng_par_in = pa;
    pulse(0, 1, 0);
    pulse(1, 0, 0);
    rd_exp(8'h14, 32'h4000_0009, "R11 status held");
    rd_exp(8'h1C, rec_val(p[0], m[0]), "R11 record held");
    rd_exp(8'h08, 32'h00CC_00AA, "R11 parity held");

    // R9 count above slots
    wr_reg(8'h00, 4'h1, 32'h0000_0005);
    wr_reg(8'h14, 4'hF, 32'h0);
    eng_err = 1'b1; eng_uncor = 1'b1; eng_err_cnt = 3'd6;
    pulse(0, 1, 0);
    rd_exp(8'h14, 32'hC000_000B, "R8 status uncorrectable");
    for (int s = 0; s < 4; s++)
      rd_exp(8'(8'h1C + 4*s), rec_val(p[s], m[s]), "R9 full record");
    rd_exp(8'h2C, 32'h0, "R9 past last record");

    // R12 interrupt
    wr_reg(8'h18, 4'h1, 32'h0000_0008);
    #1;
    check("R12 irq on decf", {31'd0, irq}, 32'd1);
    rd_exp(8'h18, 32'h8, "R12 mask readback");
    wr_reg(8'h18, 4'h1, 32'h0000_0010);
    #1;
    check("R12 irq masked", {31'd0, irq}, 32'd0);
    pulse(0, 0, 1);
    #1;
    check("R12 irq on pad", {31'd0, irq}, 32'd1);
    rd_exp(8'h14, 32'hC000_001B, "R12 pad flag");

    // R13 data port
    wr_reg(8'h04, 4'hF, 32'h1234_5678);
    #1;
    check("R13 dvld", {31'd0, eng_dvld}, 32'd1);
    check("R13 dout", eng_dout, 32'h1234_5678);
    @(negedge clk); #1;
    check("R13 dvld one cycle", {31'd0, eng_dvld}, 32'd0);
    wr_reg(8'h04, 4'h3, 32'hFFFF_AAAA);
    rd_exp(8'h04, 32'h1234_AAAA, "R13 lane merge");
    wr_reg(8'h00, 4'h1, 32'h0000_0004);
    wr_reg(8'h04, 4'hF, 32'h0);
    #1;
    check("R13 no strobe when disabled", {31'd0, eng_dvld}, 32'd0);

    repeat (4) @(negedge clk);
    if (rd_q.size() != 0) check("queue drained", rd_q.size(), 32'd0);
    summary();
    $finish;
  end
endmodule